// File: doc/BRIEF.md
# LPC Host SYNC Phase Handler

This block runs the host side of the SYNC phase of an LPC bus cycle. Once the turnaround logic hands over, it samples the 4-bit LAD nibble on every LPC clock. It sorts each sample into one of these classes: ready, short wait, long wait, ready-more, error, floating bus or reserved. From that class it decides whether the cycle goes on to a data phase, keeps waiting, or ends. A cycle ends with success, success with more DMA wanted, an error, a time-out or an invalid-pattern abort.

The sequencer that owns the address and turnaround phases pulses `start_sync` once for each byte of a transfer. On the first byte of a cycle, the block captures the cycle kind, the direction and the byte count. For every later byte, it keeps the byte index itself. An error SYNC, or a DMA peripheral that signals it wants no more transfers, ends the whole cycle early. For reads, `collect_data` tells the data phase that the two nibbles after the SYNC are still to be taken. They are then handed out as one byte.

The read byte is a valid-only stream with no back-pressure. The LPC bus cannot be paused, so the consumer must take each byte in the clock where `rd_valid` is high. All other pins are plain control and status.

Top module: `lpc_sync_engine`

## Requirements
- R1: While `rst` is high and in the first clock after it, `done`, `rd_valid`, `collect_data` and `short_overrun` are 0.
- R2: In the SYNC phase, nibble 0000 ends the byte with status 0 (ok) and 1010 ends it with status 2 (error). The status encoding is ok=0, ok_more=1, error=2, timeout=3, invalid=4. `done` is a single-clock pulse, and `status`, `cycle_end` and `done_idx` are valid only while `done` is high.
- R3: For a write, `done` rises in the clock after the terminating SYNC sample. For a read, it rises two clocks later than that, in the same clock as `rd_valid`.
- R4: If the first four samples after SYNC starts are all 1111 (nobody driving), the cycle aborts with status 3 and `done` rises in the clock after the fourth sample.
- R5: Any reserved nibble aborts the cycle with status 4 at once. Reserved means anything other than 0000, 0101, 0110, 1001 and 1010. A 1111 sampled after a wait code has been seen counts as reserved.
- R6: 1001 (ready-more) gives status 1 only when `cycle_type` is 2 (DMA). On memory (0) or I/O (1) cycles it aborts with status 4.
- R7: Short wait (0101) never aborts. The sticky output `short_overrun` goes high in the clock after the 9th consecutive short-wait sample and is cleared only by reset. A long wait breaks the run.
- R8: Long wait (0110) has no limit. `abort_in` high during a SYNC sample ends the cycle with status 3, and this takes priority over the nibble.
- R9: After a 0000, 1001 or 1010 on a read, `collect_data` is high for two clocks. The two nibbles sampled then form `rd_data` = {second, first}, and `rd_valid` pulses. `rd_suspect` is 1 exactly when the SYNC was an error. A write has no data phase.
- R10: `done_idx` counts bytes from 0 within a cycle, and `cycle_end` marks the last one. Byte count is given as 1, 2 or 4. An error, time-out or invalid result ends the cycle at once, and the next `start_sync` begins a new cycle at index 0.
- R11: On DMA cycles, 0000 ends the cycle whatever bytes remain, while 1001 moves to the next byte.
- R12: `start_sync` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst | input | 1 | Synchronous active-high reset |
| start_sync | input | 1 | Pulse: the next clock starts a SYNC phase for one byte |
| cycle_type | input | 2 | 0 memory, 1 I/O, 2 DMA; captured on the first byte |
| is_read | input | 1 | 1 = host reads from the peripheral; captured on the first byte |
| byte_count | input | CNT_W | Bytes in the cycle (1, 2 or 4); captured on the first byte |
| abort_in | input | 1 | Ends a SYNC phase with time-out status |
| lad_in | input | 4 | Sampled LAD nibble |
| collect_data | output | 1 | Data phase should clock in a read nibble |
| rd_valid | output | 1 | Read byte strobe, no back-pressure |
| rd_data | output | 8 | Read byte, high nibble sampled second |
| rd_suspect | output | 1 | Read byte followed an error SYNC |
| done | output | 1 | One-clock end-of-byte pulse |
| status | output | 3 | Result code of the byte |
| cycle_end | output | 1 | This byte closes the cycle |
| done_idx | output | CNT_W | Index of the byte just finished |
| short_overrun | output | 1 | Sticky: short-wait run went past its limit |

## Verification
On every clock, the assertions check the following:
- the single-clock shape of `done`;
- that a read strobe always coincides with `done`, and that a suspect byte carries error status;
- that the data phase lasts two clocks and never overlaps `done`;
- that `short_overrun` stays set;
- that aborts and errors always end the cycle and restart the index at 0;
- that ready-more is reported only on DMA cycles.

Only the bench's scenarios can show that each nibble value maps to the right outcome, and that the time-out, the short-wait limit and the byte index fall on the right clock. Its reference model is compared against the outputs every cycle to establish this.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_SHORT = 4'b0101;
  localparam logic [3:0] NIB_LONG  = 4'b0110;
  localparam logic [3:0] NIB_MORE  = 4'b1001;
  localparam logic [3:0] NIB_ERR   = 4'b1010;
  localparam logic [3:0] NIB_FLOAT = 4'b1111;

  localparam logic [1:0] CYC_MEM = 2'd0;
  localparam logic [1:0] CYC_IO  = 2'd1;
  localparam logic [1:0] CYC_DMA = 2'd2;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_OK_MORE = 3'd1,
    ST_ERROR   = 3'd2,
    ST_TIMEOUT = 3'd3,
    ST_INVALID = 3'd4
  } sync_status_e;

  typedef enum logic [2:0] {
    K_READY,
    K_MORE,
    K_ERR,
    K_SHORT,
    K_LONG,
    K_FLOAT,
    K_BAD
  } sync_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SYNC,
    PH_DLO,
    PH_DHI
  } phase_e;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
  import lpc_sync_pkg::*;
(
  input  logic [3:0]  lad,
  input  logic        is_dma,
  output sync_kind_e  kind
);

  always_comb begin
    case (lad)
      NIB_READY: kind = K_READY;
      NIB_SHORT: kind = K_SHORT;
      NIB_LONG:  kind = K_LONG;
      NIB_MORE:  kind = is_dma ? K_MORE : K_BAD;
      NIB_ERR:   kind = K_ERR;
      NIB_FLOAT: kind = K_FLOAT;
      default:   kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/lpc_sync_wait_track.sv
module lpc_sync_wait_track
  import lpc_sync_pkg::*;
#(
  parameter int NORESP_CLKS = 4,
  parameter int SHORT_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_start,
  input  logic       sampling,
  input  sync_kind_e kind,
  output logic       seen_valid,
  output logic       noresp_expire,
  output logic       short_overrun
);

  localparam int NR_W = $clog2(NORESP_CLKS + 1);
  localparam int SW_W = $clog2(SHORT_LIMIT + 1);

  logic [NR_W-1:0] nr_cnt;
  logic [SW_W-1:0] sw_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      nr_cnt        <= '0;
      sw_cnt        <= '0;
      seen_valid    <= 1'b0;
      short_overrun <= 1'b0;
    end else if (phase_start) begin
      nr_cnt     <= '0;
      sw_cnt     <= '0;
      seen_valid <= 1'b0;
    end else if (sampling) begin
      case (kind)
        K_SHORT: begin
          seen_valid <= 1'b1;
          if (sw_cnt == SW_W'(SHORT_LIMIT)) short_overrun <= 1'b1;
          else                               sw_cnt <= sw_cnt + 1'b1;
        end
        K_LONG: begin
          seen_valid <= 1'b1;
          sw_cnt     <= '0;
        end
        K_FLOAT: begin
          if (!seen_valid) nr_cnt <= nr_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign noresp_expire = sampling && (kind == K_FLOAT) && !seen_valid &&
                         (nr_cnt == NR_W'(NORESP_CLKS - 1));

endmodule

// File: rtl/lpc_sync_byte_seq.sv
module lpc_sync_byte_seq
  import lpc_sync_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_sync,
  input  logic [1:0]       cycle_type,
  input  logic             is_read,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             abort_in,
  input  logic [3:0]       lad,
  input  sync_kind_e       kind,
  input  logic             seen_valid,
  input  logic             noresp_expire,
  output logic             phase_start,
  output logic             sampling,
  output logic             dma_q,
  output logic [CNT_W-1:0] cur_idx,
  output logic             collect_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_suspect,
  output logic             done,
  output logic [2:0]       status,
  output logic             cycle_end,
  output logic [CNT_W-1:0] done_idx
);

  phase_e          phase;
  logic            rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]      lo_q;
  sync_status_e    pend_status;
  logic            pend_last;
  sync_status_e    status_q;

  logic            last_byte;
  logic            term, to_data, fin, fin_last;
  sync_status_e    t_status, fin_status;
  logic            t_last;

  assign last_byte    = ({1'b0, cur_idx} + 1'b1) >= {1'b0, cnt_q};
  assign phase_start  = (phase == PH_IDLE) && start_sync;
  assign sampling     = (phase == PH_SYNC);
  assign collect_data = (phase == PH_DLO) || (phase == PH_DHI);
  assign status       = status_q;

  // Outcome of one SYNC sample
  always_comb begin
    term     = 1'b0;
    to_data  = 1'b0;
    t_status = ST_OK;
    t_last   = 1'b1;
    if (sampling) begin
      if (abort_in) begin
        term     = 1'b1;
        t_status = ST_TIMEOUT;
      end else begin
        case (kind)
          K_READY: begin
            t_status = ST_OK;
            t_last   = dma_q || last_byte;
            to_data  = rd_q;
            term     = !rd_q;
          end
          K_MORE: begin
            t_status = ST_OK_MORE;
            t_last   = last_byte;
            to_data  = rd_q;
            term     = !rd_q;
          end
          K_ERR: begin
            t_status = ST_ERROR;
            to_data  = rd_q;
            term     = !rd_q;
          end
          K_FLOAT: begin
            if (seen_valid) begin
              term     = 1'b1;
              t_status = ST_INVALID;
            end else if (noresp_expire) begin
              term     = 1'b1;
              t_status = ST_TIMEOUT;
            end
          end
          K_BAD: begin
            term     = 1'b1;
            t_status = ST_INVALID;
          end
          default: ;
        endcase
      end
    end
  end

  assign fin        = term || (phase == PH_DHI);
  assign fin_status = (phase == PH_DHI) ? pend_status : t_status;
  assign fin_last   = (phase == PH_DHI) ? pend_last   : t_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      cur_idx     <= '0;
      dma_q       <= 1'b0;
      rd_q        <= 1'b0;
      cnt_q       <= '0;
      lo_q        <= '0;
      pend_status <= ST_OK;
      pend_last   <= 1'b0;
      done        <= 1'b0;
      status_q    <= ST_OK;
      cycle_end   <= 1'b0;
      done_idx    <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_suspect  <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start_sync) begin
            if (cur_idx == '0) begin
              dma_q <= (cycle_type == CYC_DMA);
              rd_q  <= is_read;
              cnt_q <= byte_count;
            end
            phase <= PH_SYNC;
          end
        end
        PH_SYNC: begin
          if (to_data) begin
            pend_status <= t_status;
            pend_last   <= t_last;
            phase       <= PH_DLO;
          end
        end
        PH_DLO: begin
          lo_q  <= lad;
          phase <= PH_DHI;
        end
        PH_DHI: begin
          rd_valid   <= 1'b1;
          rd_data    <= {lad, lo_q};
          rd_suspect <= (pend_status == ST_ERROR);
        end
        default: phase <= PH_IDLE;
      endcase
      if (fin) begin
        done      <= 1'b1;
        status_q  <= fin_status;
        cycle_end <= fin_last;
        done_idx  <= cur_idx;
        cur_idx   <= fin_last ? '0 : cur_idx + 1'b1;
        phase     <= PH_IDLE;
      end
    end
  end

endmodule

// File: rtl/lpc_sync_engine.sv
module lpc_sync_engine
  import lpc_sync_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int NORESP_CLKS = 4,
  parameter int SHORT_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_sync,
  input  logic [1:0]       cycle_type,
  input  logic             is_read,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             abort_in,
  input  logic [3:0]       lad_in,
  output logic             collect_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             rd_suspect,
  output logic             done,
  output logic [2:0]       status,
  output logic             cycle_end,
  output logic [CNT_W-1:0] done_idx,
  output logic             short_overrun
);

  sync_kind_e       kind;
  logic             dma_q;
  logic             seen_valid, noresp_expire;
  logic             phase_start, sampling;
  logic [CNT_W-1:0] cur_idx;

  lpc_sync_decode u_decode (
    .lad    (lad_in),
    .is_dma (dma_q),
    .kind   (kind)
  );

  lpc_sync_wait_track #(
    .NORESP_CLKS (NORESP_CLKS),
    .SHORT_LIMIT (SHORT_LIMIT)
  ) u_wait (
    .clk           (clk),
    .rst           (rst),
    .phase_start   (phase_start),
    .sampling      (sampling),
    .kind          (kind),
    .seen_valid    (seen_valid),
    .noresp_expire (noresp_expire),
    .short_overrun (short_overrun)
  );

  lpc_sync_byte_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_sync    (start_sync),
    .cycle_type    (cycle_type),
    .is_read       (is_read),
    .byte_count    (byte_count),
    .abort_in      (abort_in),
    .lad           (lad_in),
    .kind          (kind),
    .seen_valid    (seen_valid),
    .noresp_expire (noresp_expire),
    .phase_start   (phase_start),
    .sampling      (sampling),
    .dma_q         (dma_q),
    .cur_idx       (cur_idx),
    .collect_data  (collect_data),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rd_suspect    (rd_suspect),
    .done          (done),
    .status        (status),
    .cycle_end     (cycle_end),
    .done_idx      (done_idx)
  );

endmodule

// File: rtl/lpc_sync_checks.sv
module lpc_sync_checks #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic [2:0]       status,
  input logic             cycle_end,
  input logic             rd_valid,
  input logic             rd_suspect,
  input logic             collect_data,
  input logic             short_overrun,
  input logic             dma_q,
  input logic [CNT_W-1:0] cur_idx
);

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_status_legal_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (status <= 3'd4));

  p_rd_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> done);

  p_suspect_err_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_suspect) |-> (status == 3'd2));

  p_collect_two_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(collect_data) |=> collect_data);

  p_collect_apart_r9: assert property (@(posedge clk) disable iff (rst)
    collect_data |-> !done);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    short_overrun |=> short_overrun);

  p_abort_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (done && (status >= 3'd3)) |-> cycle_end);

  p_error_ends_r10: assert property (@(posedge clk) disable iff (rst)
    (done && (status == 3'd2)) |-> cycle_end);

  p_idx_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (done && cycle_end) |-> (cur_idx == '0));

  p_more_dma_only_r6: assert property (@(posedge clk) disable iff (rst)
    (done && (status == 3'd1)) |-> dma_q);

endmodule

bind lpc_sync_engine lpc_sync_checks #(.CNT_W(CNT_W)) u_checks (
  .clk           (clk),
  .rst           (rst),
  .done          (done),
  .status        (status),
  .cycle_end     (cycle_end),
  .rd_valid      (rd_valid),
  .rd_suspect    (rd_suspect),
  .collect_data  (collect_data),
  .short_overrun (short_overrun),
  .dma_q         (dma_q),
  .cur_idx       (cur_idx)
);

// File: tb/test_lpc_sync_engine.sv
module test_lpc_sync_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_sync = 1'b0;
  logic [1:0] cycle_type = 2'd0;
  logic       is_read = 1'b0;
  logic [2:0] byte_count = 3'd1;
  logic       abort_in = 1'b0;
  logic [3:0] lad_in = 4'hF;
  logic       collect_data, rd_valid, rd_suspect, done, cycle_end, short_overrun;
  logic [7:0] rd_data;
  logic [2:0] status;
  logic [2:0] done_idx;

  always #10 clk = ~clk;

  lpc_sync_engine i_lpc_sync_engine (
    .clk(clk), .rst(rst), .start_sync(start_sync), .cycle_type(cycle_type),
    .is_read(is_read), .byte_count(byte_count), .abort_in(abort_in),
    .lad_in(lad_in), .collect_data(collect_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_suspect(rd_suspect), .done(done), .status(status),
    .cycle_end(cycle_end), .done_idx(done_idx), .short_overrun(short_overrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string scn_tag = "R3";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model (state 0 idle, 1 sync, 2 first data, 3 second data)
  int m_state, m_idx, m_cnt, m_float, m_short, m_pend;
  bit m_dma, m_rd, m_seen, m_pend_last;
  int m_lo;
  bit e_done, e_last, e_rdv, e_sus, e_ovr;
  int e_status, e_idx, e_rdd;
  string e_tag, m_pend_tag;
  bit model_on = 1'b0;

  function automatic void m_finish(int st, bit lst, string tag);
    e_done = 1; e_status = st; e_last = lst; e_idx = m_idx; e_tag = tag;
    m_idx = lst ? 0 : m_idx + 1;
    m_state = 0;
  endfunction

  function automatic void m_end_sync(int st, bit lst, string tag);
    if (m_rd) begin
      m_pend = st; m_pend_last = lst; m_pend_tag = tag; m_state = 2;
    end else m_finish(st, lst, tag);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_idx = 0; m_cnt = 1; m_float = 0; m_short = 0;
      m_dma = 0; m_rd = 0; m_seen = 0; m_lo = 0; m_pend = 0; m_pend_last = 0;
      e_done = 0; e_last = 0; e_rdv = 0; e_sus = 0; e_ovr = 0;
      e_status = 0; e_idx = 0; e_rdd = 0; e_tag = "R1";
    end else begin
      bit lastb;
      e_done = 0; e_rdv = 0;
      lastb = (m_idx + 1 >= m_cnt);
      case (m_state)
        0: if (start_sync) begin
          if (m_idx == 0) begin
            m_dma = (cycle_type == 2'd2); m_rd = is_read; m_cnt = byte_count;
          end
          m_seen = 0; m_float = 0; m_short = 0; m_state = 1;
        end
        1: begin
          if (abort_in) m_finish(3, 1, "R8");
          else if (lad_in == 4'h0)
            m_end_sync(0, m_dma || lastb, (m_dma && !lastb) ? "R11" : (lastb ? "R2" : "R10"));
          else if (lad_in == 4'h9) begin
            if (m_dma) m_end_sync(1, lastb, "R11");
            else m_finish(4, 1, "R6");
          end else if (lad_in == 4'hA) m_end_sync(2, 1, (m_idx > 0 || m_cnt > 1) ? "R10" : "R2");
          else if (lad_in == 4'h5) begin
            m_seen = 1;
            if (m_short >= 8) e_ovr = 1; else m_short++;
          end else if (lad_in == 4'h6) begin
            m_seen = 1; m_short = 0;
          end else if (lad_in == 4'hF && !m_seen) begin
            m_float++;
            if (m_float == 4) m_finish(3, 1, "R4");
          end else m_finish(4, 1, "R5");
        end
        2: begin m_lo = lad_in; m_state = 3; end
        default: begin
          e_rdv = 1; e_rdd = lad_in * 16 + m_lo; e_sus = (m_pend == 2);
          m_finish(m_pend, m_pend_last, "R9");
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(e_done ? e_tag : scn_tag, "done", done, e_done);
      chk("R9", "collect_data", collect_data, (m_state == 2 || m_state == 3));
      chk("R9", "rd_valid", rd_valid, e_rdv);
      chk("R7", "short_overrun", short_overrun, e_ovr);
      if (e_done) begin
        chk(e_tag, "status", status, e_status);
        chk(e_tag, "cycle_end", cycle_end, e_last);
        chk("R10", "done_idx", done_idx, e_idx);
      end
      if (e_rdv) begin
        chk("R9", "rd_data", rd_data, e_rdd);
        chk("R9", "rd_suspect", rd_suspect, e_sus);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", wd);
      report();
    end
  end

  task automatic idle(input int n);
    lad_in = 4'hF;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic open_byte(input logic [1:0] ct, input logic rd, input logic [2:0] bc);
    @(negedge clk);
    start_sync = 1; cycle_type = ct; is_read = rd; byte_count = bc;
    @(negedge clk);
    start_sync = 0;
  endtask

  task automatic nib(input logic [3:0] v);
    lad_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1", "done in reset", done, 0);
    chk("R1", "rd_valid in reset", rd_valid, 0);
    chk("R1", "collect in reset", collect_data, 0);
    chk("R1", "overrun in reset", short_overrun, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "done after reset", done, 0);
    chk("R1", "overrun after reset", short_overrun, 0);
    model_on = 1;

    // R2/R3: I/O write, ready after long waits
    open_byte(2'd1, 0, 3'd1); nib(4'h6); nib(4'h6); nib(4'h0); idle(2);
    // R9: I/O read ready, data 0x5A
    open_byte(2'd1, 1, 3'd1); nib(4'h0); nib(4'hA); nib(4'h5); idle(2);
    // R10: 4-byte memory read
    for (int b = 0; b < 4; b++) begin
      open_byte(2'd0, 1, 3'd4); nib(4'h6); nib(4'h0); nib(4'(b)); nib(4'(b + 3)); idle(1);
    end
    // R10: error on first byte ends the cycle, then a fresh cycle at index 0
    open_byte(2'd0, 1, 3'd4); nib(4'hA); nib(4'h3); nib(4'hC); idle(1);
    open_byte(2'd1, 0, 3'd1); nib(4'h0); idle(1);
    // R2: error on a write
    open_byte(2'd1, 0, 3'd1); nib(4'hA); idle(1);
    // R4: nobody answers
    open_byte(2'd1, 1, 3'd1); nib(4'hF); nib(4'hF); nib(4'hF); nib(4'hF); idle(2);
    // R4: three floating samples then ready is fine
    open_byte(2'd1, 0, 3'd1); nib(4'hF); nib(4'hF); nib(4'hF); nib(4'h0); idle(1);
    // R5: reserved code and late float
    open_byte(2'd0, 0, 3'd1); nib(4'h3); idle(1);
    open_byte(2'd0, 0, 3'd1); nib(4'h6); nib(4'hF); idle(1);
    // R6: ready-more on I/O
    open_byte(2'd1, 0, 3'd1); nib(4'h9); idle(1);
    // R11: DMA 2-byte, ready-more then ready
    open_byte(2'd2, 1, 3'd2); nib(4'h9); nib(4'h1); nib(4'h2); idle(1);
    open_byte(2'd2, 1, 3'd2); nib(4'h0); nib(4'h4); nib(4'h8); idle(1);
    // R11: DMA 4-byte, ready on first byte ends the cycle
    open_byte(2'd2, 0, 3'd4); nib(4'h0); idle(1);
    open_byte(2'd1, 0, 3'd1); nib(4'h0); idle(1);
    // R11: DMA error on a write
    open_byte(2'd2, 0, 3'd2); nib(4'hA); idle(1);
    // R7: 8 shorts, long, 8 shorts: no overrun
    open_byte(2'd1, 0, 3'd1);
    for (int i = 0; i < 8; i++) nib(4'h5);
    nib(4'h6);
    for (int i = 0; i < 8; i++) nib(4'h5);
    nib(4'h0); idle(1);
    // R7: 10 shorts: overrun, no abort
    open_byte(2'd1, 1, 3'd1);
    for (int i = 0; i < 10; i++) nib(4'h5);
    nib(4'h0); nib(4'h7); nib(4'hE); idle(2);
    // R8: long wait of 40 clocks, then external abort in a long wait
    open_byte(2'd0, 0, 3'd1);
    for (int i = 0; i < 40; i++) nib(4'h6);
    nib(4'h0); idle(1);
    open_byte(2'd0, 1, 3'd1); nib(4'h6); nib(4'h6);
    abort_in = 1; nib(4'h6); abort_in = 0; idle(2);
    // R12: start_sync held during SYNC and data is ignored
    scn_tag = "R12";
    open_byte(2'd1, 1, 3'd1);
    start_sync = 1; nib(4'h6); nib(4'h0); nib(4'h1); nib(4'h2);
    start_sync = 0; idle(3);
    scn_tag = "R3";
    idle(3);
    report();
  end

endmodule